// File: doc/BRIEF.md
# SCSI Target Selection Detector

This block watches the control lines and data byte of a parallel SCSI bus on behalf of a target device that may answer to any of eight IDs. Software enables IDs through an 8-bit mask. When the initiator holds SEL with BSY released and places a bit on the data byte that lands on an enabled ID, a qualification counter must run out before the selection is accepted. Once accepted, a selected flag and the winning ID are latched. They stay latched even if the initiator lets go of SEL early, until software reads the status.

A bus reset seen on the RST line sets a sticky status bit that only a controller reset clears. The interrupt line is high whenever either flag is set. A small flags register selects the short or the long qualification time, turns parity checking of the ID byte on, and can bypass a two-sample glitch filter on the bus inputs. Driving BSY in response and the phases after selection belong to other logic.

Top module: `scsi_sel_detect`

## Requirements
- R1: After a controller reset the status byte reads 0, irq is low, the ID mask is 0 and the flags register is 0 (glitch filter active, parity off, long qualification).
- R2: With flags bit2 (fast) set and flags bit0 set (filter bypassed), a selection is accepted when SEL=1, BSY=0 and a data bit that is set in the mask hold together for 5 consecutive clock edges. Status bit0 (selected) reads 1 after the 6th edge that sampled the condition, and not before.
- R3: With flags bit2 clear the qualification count is 43 edges instead of 5.
- R4: If the condition drops for one sampled cycle before the count expires, the count restarts from zero.
- R5: No selection occurs while BSY=1, when no data bit matches the mask, or when the mask is 0.
- R6: The selected flag stays set after SEL is released, and it is cleared by the edge at which stat_rd is high.
- R7: Status bits 4:2 give the highest-numbered ID that is both set on the data byte and enabled in the mask. They read 0 while the selected flag is clear.
- R8: A high RST line sets status bit1 (bus reset). The bit is not cleared by stat_rd; only the controller reset clears it. With the filter bypassed, it reads 1 after the second edge following a one-cycle RST pulse.
- R9: irq is high exactly when status bit0 or status bit1 is set.
- R10: With flags bit0 clear, each bus input must be sampled at the same level on two consecutive edges before it takes effect. A one-cycle pulse is ignored, and acceptance comes one edge later than in R2.
- R11: With flags bit1 set, the condition also requires odd parity over the data byte and bus_par_i together.
- R12: Register writes use reg_addr 0 for the ID mask and reg_addr 1 for the flags, taking bits 2:0 of reg_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = ID mask, 1 = flags |
| reg_wdata | input | 8 | Register write data |
| bus_sel_i | input | 1 | SEL line, 1 = asserted |
| bus_bsy_i | input | 1 | BSY line, 1 = asserted |
| bus_rst_i | input | 1 | RST line, 1 = asserted |
| bus_data_i | input | 8 | Data byte, 1 = bit asserted |
| bus_par_i | input | 1 | Data parity line |
| stat_rd | input | 1 | Status read strobe, clears the selected flag |
| stat_data | output | 8 | bit0 selected, bit1 bus reset, bits 4:2 selected ID |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that the bus lines are already synchronised to clk. They also assume stat_rd is a single-cycle strobe that is not raised in the same cycle a selection completes, and that the qualification setting is not changed while a count is running. The bench drives every input at the falling edge and changes the flags only while the bus is idle. It raises stat_rd for exactly one cycle, and only after the selection has already latched.

// File: rtl/seldet_pkg.sv
package seldet_pkg;

    localparam int ID_W  = 8;
    localparam int IDX_W = $clog2(ID_W);
    localparam int STAT_W = 8;
    localparam int STAT_PAD = STAT_W - 2 - IDX_W;

    // Sampled bus lines, all active high.
    typedef struct packed {
        logic            sel;
        logic            bsy;
        logic            rst;
        logic            par;
        logic [ID_W-1:0] data;
    } bus_t;

    localparam int BUS_W = $bits(bus_t);

    // Flags register: bit2 fast, bit1 parity enable, bit0 filter bypass.
    typedef struct packed {
        logic fast;
        logic par_en;
        logic glitch_off;
    } flags_t;

    localparam int FLAGS_W = $bits(flags_t);

    // Highest-numbered set bit wins.
    function automatic logic [IDX_W-1:0] top_id(input logic [ID_W-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < ID_W; i++) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    function automatic logic odd_parity(input logic [ID_W:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/seldet_filter.sv
module seldet_filter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bypass,
    input  logic [W-1:0] raw,
    output logic [W-1:0] filt
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic last_q;
        logic held_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                last_q <= 1'b0;
                held_q <= 1'b0;
            end else begin
                last_q <= raw[i];
                if (bypass || (raw[i] == last_q)) begin
                    held_q <= raw[i];
                end
            end
        end

        assign filt[i] = held_q;
    end

endmodule

// File: rtl/seldet_qual.sv
module seldet_qual
    import seldet_pkg::*;
#(
    parameter int unsigned SLOW_QUAL = 43,
    parameter int unsigned FAST_QUAL = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fast,
    input  logic             par_en,
    input  logic [ID_W-1:0]  id_mask,
    input  bus_t             bus,
    output logic             accept,
    output logic [IDX_W-1:0] hit_id
);

    localparam int CNT_W = $clog2(SLOW_QUAL + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic [ID_W-1:0]  hits;
    logic             par_ok;
    logic             cond;

    assign limit  = fast ? CNT_W'(FAST_QUAL) : CNT_W'(SLOW_QUAL);
    assign hits   = bus.data & id_mask;
    assign par_ok = !par_en || odd_parity({bus.par, bus.data});
    assign cond   = bus.sel && !bus.bsy && (|hits) && par_ok;

    always_ff @(posedge clk) begin
        if (rst || !cond) begin
            cnt <= '0;
        end else if (cnt < limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign accept = cond && (cnt == limit - 1'b1);
    assign hit_id = top_id(hits);

    // R4: acceptance needs the condition to have been present the cycle before too
    assert_accept_after_hold_R4: assert property (@(posedge clk) disable iff (rst)
        accept |-> $past(cond));

endmodule

// File: rtl/scsi_sel_detect.sv
module scsi_sel_detect
    import seldet_pkg::*;
#(
    parameter int unsigned SLOW_QUAL = 43,
    parameter int unsigned FAST_QUAL = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              bus_sel_i,
    input  logic              bus_bsy_i,
    input  logic              bus_rst_i,
    input  logic [ID_W-1:0]   bus_data_i,
    input  logic              bus_par_i,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_data,
    output logic              irq
);

    logic [ID_W-1:0]  id_mask;
    flags_t           flags;
    bus_t             raw_bus;
    bus_t             filt_bus;
    logic             accept;
    logic [IDX_W-1:0] hit_id;
    logic [IDX_W-1:0] sel_id;
    logic             sel_flag;
    logic             rst_flag;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[7:FLAGS_W];

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            id_mask <= '0;
            flags   <= '0;
        end else if (reg_we) begin
            if (reg_addr == 1'b0) id_mask <= reg_wdata[ID_W-1:0];
            else                  flags   <= flags_t'(reg_wdata[FLAGS_W-1:0]);
        end
    end

    assign raw_bus.sel  = bus_sel_i;
    assign raw_bus.bsy  = bus_bsy_i;
    assign raw_bus.rst  = bus_rst_i;
    assign raw_bus.par  = bus_par_i;
    assign raw_bus.data = bus_data_i;

    seldet_filter #(.W(BUS_W)) i_filter (
        .clk    (clk),
        .rst    (rst),
        .bypass (flags.glitch_off),
        .raw    (raw_bus),
        .filt   (filt_bus)
    );

    seldet_qual #(
        .SLOW_QUAL (SLOW_QUAL),
        .FAST_QUAL (FAST_QUAL)
    ) i_qual (
        .clk     (clk),
        .rst     (rst),
        .fast    (flags.fast),
        .par_en  (flags.par_en),
        .id_mask (id_mask),
        .bus     (filt_bus),
        .accept  (accept),
        .hit_id  (hit_id)
    );

    // Latched status; a completing selection wins over a read in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_flag <= 1'b0;
            sel_id   <= '0;
            rst_flag <= 1'b0;
        end else begin
            if (accept) begin
                sel_flag <= 1'b1;
                if (!sel_flag) sel_id <= hit_id;
            end else if (stat_rd) begin
                sel_flag <= 1'b0;
            end
            if (filt_bus.rst) rst_flag <= 1'b1;
        end
    end

    assign stat_data = {{STAT_PAD{1'b0}}, (sel_flag ? sel_id : {IDX_W{1'b0}}), rst_flag, sel_flag};
    assign irq       = sel_flag | rst_flag;

    // R8: the bus reset status never clears without a controller reset
    assert_rst_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        rst_flag |=> rst_flag);

    // R6: a status read with no completing selection clears the flag
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !accept) |=> !sel_flag);

    // R5: a selection can only rise while some ID is enabled
    assert_mask_gate_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_flag) |-> $past(id_mask != '0));

endmodule

// File: tb/test_scsi_sel_detect.sv
module test_scsi_sel_detect;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       bus_sel_i = 1'b0;
    logic       bus_bsy_i = 1'b0;
    logic       bus_rst_i = 1'b0;
    logic [7:0] bus_data_i = '0;
    logic       bus_par_i = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_data;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [8:0] exp;
        string      req;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    scsi_sel_detect i_scsi_sel_detect (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .bus_sel_i  (bus_sel_i),
        .bus_bsy_i  (bus_bsy_i),
        .bus_rst_i  (bus_rst_i),
        .bus_data_i (bus_data_i),
        .bus_par_i  (bus_par_i),
        .stat_rd    (stat_rd),
        .stat_data  (stat_data),
        .irq        (irq)
    );

    // Monitor: after each rising edge compare {irq, status} with queued items.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if ({irq, stat_data} !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", it.req, {irq, stat_data}, it.exp);
                end
            end
        end
    end

    // Driver: push the expectation for the next edge, then move to the next falling edge.
    task automatic exp_edge(input logic [8:0] e, input string req);
        sb.push_back('{e, req});
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic bus(input logic s, input logic b, input logic [7:0] d, input logic p);
        bus_sel_i = s; bus_bsy_i = b; bus_data_i = d; bus_par_i = p;
    endtask

    task automatic read_status();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    localparam logic [8:0] SEL3 = 9'h10D;   // irq, id 3, selected
    localparam logic [8:0] SEL5 = 9'h115;   // irq, id 5, selected
    localparam logic [8:0] RSTF = 9'h102;   // irq, bus reset

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_edge(9'h000, "R1 reset state");

        // R12: mask enables ID 3, flags = fast + filter bypass
        wr(1'b0, 8'h08);
        wr(1'b1, 8'h05);

        // R2: five qualifying edges, flag after the sixth
        bus(1, 0, 8'h88, 0);
        repeat (5) exp_edge(9'h000, "R2 before expiry");
        exp_edge(SEL3, "R2 selected id3 R9 irq");

        // R6: release SEL, flag stays latched
        bus(0, 0, 8'h00, 0);
        repeat (2) exp_edge(SEL3, "R6 latched after SEL release");
        stat_rd = 1'b1;
        exp_edge(9'h000, "R6 cleared by read R7 id hidden");
        stat_rd = 1'b0;

        // R4: condition drops after three edges, count restarts
        bus(1, 0, 8'h88, 0);
        repeat (3) exp_edge(9'h000, "R4 partial hold");
        bus(0, 0, 8'h88, 0);
        exp_edge(9'h000, "R4 drop");
        bus(1, 0, 8'h88, 0);
        repeat (5) exp_edge(9'h000, "R4 restarted count");
        exp_edge(SEL3, "R4 selected after full count");
        bus(0, 0, 8'h00, 0);
        read_status();

        // R5: BSY high, mismatched ID, empty mask
        bus(1, 1, 8'h88, 0);
        repeat (8) exp_edge(9'h000, "R5 bsy blocks");
        bus(1, 0, 8'hA0, 0);
        repeat (8) exp_edge(9'h000, "R5 no matching id");
        bus(0, 0, 8'h00, 0);
        wr(1'b0, 8'h00);
        bus(1, 0, 8'h88, 0);
        repeat (8) exp_edge(9'h000, "R5 mask zero");
        bus(0, 0, 8'h00, 0);

        // R7: IDs 3 and 5 enabled, both present, 5 wins
        wr(1'b0, 8'h28);
        bus(1, 0, 8'hA8, 0);
        repeat (5) exp_edge(9'h000, "R7 counting");
        exp_edge(SEL5, "R7 highest id");
        bus(0, 0, 8'h00, 0);
        read_status();

        // R11: parity checking on
        wr(1'b1, 8'h07);
        bus(1, 0, 8'h88, 0);
        repeat (8) exp_edge(9'h000, "R11 even parity rejected");
        bus(1, 0, 8'h88, 1);
        repeat (5) exp_edge(9'h000, "R11 counting");
        exp_edge(SEL3, "R11 odd parity accepted");
        bus(0, 0, 8'h00, 0);
        read_status();

        // R10: glitch filter active, one extra edge of latency
        wr(1'b1, 8'h04);
        @(negedge clk);
        bus(1, 0, 8'h88, 0);
        repeat (6) exp_edge(9'h000, "R10 filtered counting");
        exp_edge(SEL3, "R10 filtered selection");
        bus(0, 0, 8'h00, 0);
        repeat (2) @(negedge clk);
        read_status();
        bus_rst_i = 1'b1;
        exp_edge(9'h000, "R10 rst pulse sampled");
        bus_rst_i = 1'b0;
        repeat (4) exp_edge(9'h000, "R10 one-cycle rst ignored");

        // R8: filter bypassed, one-cycle bus reset is latched
        wr(1'b1, 8'h05);
        bus_rst_i = 1'b1;
        exp_edge(9'h000, "R8 pulse sampled");
        bus_rst_i = 1'b0;
        exp_edge(RSTF, "R8 reset flag R9 irq");
        stat_rd = 1'b1;
        exp_edge(RSTF, "R8 read does not clear");
        stat_rd = 1'b0;
        exp_edge(RSTF, "R8 sticky");
        rst = 1'b1;
        exp_edge(9'h000, "R8 cleared by controller reset");
        rst = 1'b0;

        // R3: long qualification
        wr(1'b0, 8'h08);
        wr(1'b1, 8'h01);
        bus(1, 0, 8'h88, 0);
        repeat (43) exp_edge(9'h000, "R3 long counting");
        exp_edge(SEL3, "R3 long selection");
        bus(0, 0, 8'h00, 0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule